// File: doc/BRIEF.md
# Processor Status Word and Branch-Condition Unit

This block keeps the processor's 16-bit status word and turns it into control decisions. The upper nibble carries four arithmetic condition flags written by the ALU. The lower byte is a per-device interrupt-enable field, one bit for each of eight request lines. Between them sits a reserved nibble that always reads zero.

The enable-mask instruction sets bits in the enable field by OR. The disable-mask instruction clears bits by AND. On return from an interrupt, the whole word is reloaded from the value taken off the stack. On a trap, the sequencer saves the word from the `status_word` output. Interrupt vectoring and the stack writes belong to other blocks.

Two combinational results come from the registered word:
- A 2-bit condition selector picks one flag. The `taken` output tells the sequencer whether a conditional branch or a conditional subroutine call goes ahead.
- The external request lines are gated by the enable field. The lowest-numbered surviving request is reported as an index with a valid flag.

The request lines are numbered 0 to 7 in this order: timer 0, A/D converter, timer 1, serial 1, serial 2, parallel, video, keyboard.

The block has no sequencing state of its own. Its only state is the status register, which moves between two named conditions:
- **hold**: no update input is active, so the word keeps its value.
- **load**: an update is applied at the next rising clock edge.

Top module: `status_branch_unit`

## Requirements
- R1: After reset, `status_word` is 0. With the word at 0, `taken` is 0 for every selector value and `irq_valid` is 0, so all interrupts start disabled.
- R2: When `flag_we` is 1 and `restore_en` is 0, bits 15..12 take `flag_in` at the next rising edge. The mapping is `flag_in[3]`=N to bit 15, `flag_in[2]`=Z to bit 14, `flag_in[1]`=C to bit 13 and `flag_in[0]`=O to bit 12. Bits 7..0 are not changed by a flag update.
- R3: When `mask_en` is 1, `mask_set` is 1 and `restore_en` is 0, bits 7..0 become their old value OR `mask_val`. Bits 15..12 are not changed by a mask instruction.
- R4: When `mask_en` is 1, `mask_set` is 0 and `restore_en` is 0, bits 7..0 become their old value AND `mask_val`.
- R5: When `restore_en` is 1, the word takes `restore_word` at the next edge, with bits 11..8 forced to zero. A restore overrides any flag update or mask instruction presented in the same cycle.
- R6: Bits 11..8 of `status_word` always read 0, whatever is written to them.
- R7: `taken` equals the flag chosen by `cond_sel`, and follows it in the same cycle. The codes are 00 → N (bit 15), 01 → Z (bit 14), 10 → C (bit 13) and 11 → O (bit 12).
- R8: `irq_valid` is 1 exactly when some bit of `irq_req` AND bits 7..0 is 1. `irq_index` then gives the lowest-numbered such line. `irq_index` is 0 when `irq_valid` is 0. Both outputs are combinational.
- R9: A flag update and a mask instruction in the same cycle (with no restore) both take effect, each on its own field.
- R10: With no update input active, `status_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_we | input | 1 | Flag update strobe from the ALU |
| flag_in | input | 4 | New flags {N,Z,C,O} |
| mask_en | input | 1 | Mask instruction strobe |
| mask_set | input | 1 | 1 = enable (OR), 0 = disable (AND) |
| mask_val | input | 8 | 8-bit interrupt mask operand |
| restore_en | input | 1 | Whole-word reload strobe (return from interrupt) |
| restore_word | input | 16 | Word taken off the stack |
| irq_req | input | 8 | External interrupt request lines |
| cond_sel | input | 2 | Condition selector for branches and calls |
| status_word | output | 16 | Current status word (saved on trap) |
| taken | output | 1 | Selected flag is set |
| irq_valid | output | 1 | An enabled request is active |
| irq_index | output | 3 | Lowest-numbered enabled active request |

## Verification
The status register is the block's only state. A wrong bit in it shows on `status_word` one cycle after the update that caused it. The same wrong bit propagates within that cycle to `taken`, for the selector reading that flag, and to the interrupt outputs, for any request line that lands on that enable bit. The bench therefore compares the word after every clock, and compares `taken` and the interrupt outputs before every clock. A misordered priority between restore and the other updates, or a mask applied with the wrong operator, appears on the very next cycle's word.

// File: rtl/sw_pkg.sv
`timescale 1ns/1ps
package sw_pkg;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        COND_NEG   = 2'b00,
        COND_ZERO  = 2'b01,
        COND_CARRY = 2'b10,
        COND_OVF   = 2'b11
    } cond_e;

    typedef enum logic {
        REG_HOLD = 1'b0,
        REG_LOAD = 1'b1
    } reg_mode_e;
endpackage

// File: rtl/sw_word_reg.sv
`timescale 1ns/1ps
module sw_word_reg #(
    parameter int IRQ_W  = 8,
    parameter int RSV_W  = 4,
    localparam int FLAG_W = sw_pkg::FLAG_W,
    localparam int WORD_W = FLAG_W + RSV_W + IRQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic              mask_en,
    input  logic              mask_set,
    input  logic [IRQ_W-1:0]  mask_val,
    input  logic              restore_en,
    input  logic [WORD_W-1:0] restore_word,
    output logic [WORD_W-1:0] word_q
);
    import sw_pkg::*;

    localparam int FLAG_LO = IRQ_W + RSV_W;

    reg_mode_e         mode;
    logic [WORD_W-1:0] word_d;

    assign mode = (restore_en || flag_we || mask_en) ? REG_LOAD : REG_HOLD;

    // Restore wins over everything; flag and mask fields are disjoint.
    always_comb begin
        word_d = word_q;
        unique case (mode)
            REG_HOLD: word_d = word_q;
            REG_LOAD: begin
                if (restore_en) begin
                    word_d = restore_word;
                end else begin
                    if (flag_we)
                        word_d[WORD_W-1:FLAG_LO] = flag_in;
                    if (mask_en)
                        word_d[IRQ_W-1:0] = mask_set ? (word_q[IRQ_W-1:0] | mask_val)
                                                     : (word_q[IRQ_W-1:0] & mask_val);
                end
            end
            default: word_d = word_q;
        endcase
        word_d[FLAG_LO-1:IRQ_W] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else
            word_q <= word_d;
    end
endmodule

// File: rtl/sw_cond_sel.sv
`timescale 1ns/1ps
module sw_cond_sel (
    input  logic [sw_pkg::FLAG_W-1:0] flags,
    input  logic [1:0]                cond_sel,
    output logic                      taken
);
    import sw_pkg::*;

    cond_e sel;
    assign sel = cond_e'(cond_sel);

    // flags = {N, Z, C, O}
    always_comb begin
        unique case (sel)
            COND_NEG:   taken = flags[3];
            COND_ZERO:  taken = flags[2];
            COND_CARRY: taken = flags[1];
            COND_OVF:   taken = flags[0];
            default:    taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/sw_irq_pick.sv
`timescale 1ns/1ps
module sw_irq_pick #(
    parameter int IRQ_W = 8,
    localparam int IDX_W = (IRQ_W > 1) ? $clog2(IRQ_W) : 1
) (
    input  logic [IRQ_W-1:0] req,
    input  logic [IRQ_W-1:0] enable,
    output logic             valid,
    output logic [IDX_W-1:0] index
);
    logic [IRQ_W-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < IRQ_W; g++) begin : g_gate
            assign hit[g] = req[g] & enable[g];
        end
    endgenerate

    assign valid = |hit;

    // Scan from the top so the lowest-numbered hit is assigned last.
    always_comb begin
        index = '0;
        for (int i = IRQ_W - 1; i >= 0; i--) begin
            if (hit[i])
                index = IDX_W'(i);
        end
    end
endmodule

// File: rtl/status_branch_unit.sv
`timescale 1ns/1ps
module status_branch_unit #(
    parameter int IRQ_W  = 8,
    parameter int RSV_W  = 4,
    localparam int FLAG_W = sw_pkg::FLAG_W,
    localparam int WORD_W = FLAG_W + RSV_W + IRQ_W,
    localparam int IDX_W  = (IRQ_W > 1) ? $clog2(IRQ_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic [FLAG_W-1:0] flag_in,
    input  logic              mask_en,
    input  logic              mask_set,
    input  logic [IRQ_W-1:0]  mask_val,
    input  logic              restore_en,
    input  logic [WORD_W-1:0] restore_word,
    input  logic [IRQ_W-1:0]  irq_req,
    input  logic [1:0]        cond_sel,
    output logic [WORD_W-1:0] status_word,
    output logic              taken,
    output logic              irq_valid,
    output logic [IDX_W-1:0]  irq_index
);
    sw_word_reg #(.IRQ_W(IRQ_W), .RSV_W(RSV_W)) u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .flag_we      (flag_we),
        .flag_in      (flag_in),
        .mask_en      (mask_en),
        .mask_set     (mask_set),
        .mask_val     (mask_val),
        .restore_en   (restore_en),
        .restore_word (restore_word),
        .word_q       (status_word)
    );

    sw_cond_sel u_cond (
        .flags    (status_word[WORD_W-1 -: FLAG_W]),
        .cond_sel (cond_sel),
        .taken    (taken)
    );

    sw_irq_pick #(.IRQ_W(IRQ_W)) u_pick (
        .req    (irq_req),
        .enable (status_word[IRQ_W-1:0]),
        .valid  (irq_valid),
        .index  (irq_index)
    );
endmodule

// File: rtl/sw_checker.sv
`timescale 1ns/1ps
module sw_checker #(
    parameter int IRQ_W  = 8,
    parameter int RSV_W  = 4,
    localparam int FLAG_W = 4,
    localparam int WORD_W = FLAG_W + RSV_W + IRQ_W,
    localparam int IDX_W  = (IRQ_W > 1) ? $clog2(IRQ_W) : 1,
    localparam int FLAG_LO = IRQ_W + RSV_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flag_in,
    input logic              mask_en,
    input logic              mask_set,
    input logic [IRQ_W-1:0]  mask_val,
    input logic              restore_en,
    input logic [WORD_W-1:0] restore_word,
    input logic [IRQ_W-1:0]  irq_req,
    input logic [1:0]        cond_sel,
    input logic [WORD_W-1:0] status_word,
    input logic              taken,
    input logic              irq_valid,
    input logic [IDX_W-1:0]  irq_index
);
    logic [WORD_W-1:0] rsv_keep;
    assign rsv_keep = ~({{(WORD_W-RSV_W){1'b0}}, {RSV_W{1'b1}}} << IRQ_W);

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[FLAG_LO-1:IRQ_W] == '0);

    assert_restore_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> status_word == ($past(restore_word) & rsv_keep));

    assert_flag_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && flag_we) |=> status_word[WORD_W-1:FLAG_LO] == $past(flag_in));

    assert_enable_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && mask_en && mask_set) |=>
        status_word[IRQ_W-1:0] == ($past(status_word[IRQ_W-1:0]) | $past(mask_val)));

    assert_disable_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && mask_en && !mask_set) |=>
        status_word[IRQ_W-1:0] == ($past(status_word[IRQ_W-1:0]) & $past(mask_val)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore_en && !flag_we && !mask_en) |=> $stable(status_word));

    assert_taken_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken == status_word[WORD_W - 1 - int'(cond_sel)]);

    assert_irq_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid == (|(irq_req & status_word[IRQ_W-1:0])));

    assert_irq_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_req[irq_index] && status_word[irq_index]));

    assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid |-> irq_index == '0);
endmodule

bind status_branch_unit sw_checker #(.IRQ_W(IRQ_W), .RSV_W(RSV_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_we      (flag_we),
    .flag_in      (flag_in),
    .mask_en      (mask_en),
    .mask_set     (mask_set),
    .mask_val     (mask_val),
    .restore_en   (restore_en),
    .restore_word (restore_word),
    .irq_req      (irq_req),
    .cond_sel     (cond_sel),
    .status_word  (status_word),
    .taken        (taken),
    .irq_valid    (irq_valid),
    .irq_index    (irq_index)
);

// File: tb/test_status_branch_unit.sv
`timescale 1ns/1ps
module test_status_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flag_we = 1'b0;
    logic [3:0]  flag_in = '0;
    logic        mask_en = 1'b0;
    logic        mask_set = 1'b0;
    logic [7:0]  mask_val = '0;
    logic        restore_en = 1'b0;
    logic [15:0] restore_word = '0;
    logic [7:0]  irq_req = '0;
    logic [1:0]  cond_sel = '0;
    logic [15:0] status_word;
    logic        taken;
    logic        irq_valid;
    logic [2:0]  irq_index;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] model = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    status_branch_unit i_status_branch_unit (
        .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_in(flag_in),
        .mask_en(mask_en), .mask_set(mask_set), .mask_val(mask_val),
        .restore_en(restore_en), .restore_word(restore_word), .irq_req(irq_req),
        .cond_sel(cond_sel), .status_word(status_word), .taken(taken),
        .irq_valid(irq_valid), .irq_index(irq_index)
    );

    function automatic logic [15:0] f_next(logic [15:0] w, logic fw, logic [3:0] fi,
                                           logic me, logic ms, logic [7:0] mv,
                                           logic re, logic [15:0] rw);
        logic [15:0] n = w;
        if (re) n = rw;
        else begin
            if (fw) n[15:12] = fi;
            if (me) n[7:0] = ms ? (w[7:0] | mv) : (w[7:0] & mv);
        end
        n[11:8] = 4'h0;
        return n;
    endfunction

    function automatic logic f_taken(logic [15:0] w, logic [1:0] s);
        case (s)
            2'b00:   return w[15];
            2'b01:   return w[14];
            2'b10:   return w[13];
            default: return w[12];
        endcase
    endfunction

    function automatic logic [3:0] f_pick(logic [7:0] req, logic [7:0] en);
        for (int i = 0; i < 8; i++)
            if (req[i] && en[i]) return {1'b1, 3'(i)};
        return 4'b0000;
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Inputs driven at negedge; comb outputs checked mid-low phase;
    // register checked at the following negedge.
    task automatic step(string tag, logic fw, logic [3:0] fi, logic me, logic ms,
                        logic [7:0] mv, logic re, logic [15:0] rw,
                        logic [7:0] rq, logic [1:0] cs);
        flag_we = fw; flag_in = fi; mask_en = me; mask_set = ms; mask_val = mv;
        restore_en = re; restore_word = rw; irq_req = rq; cond_sel = cs;
        #5;
        chk({tag, " R7 taken"}, 32'(taken), 32'(f_taken(model, cs)));
        chk({tag, " R8 irq"}, 32'({irq_valid, irq_index}), 32'(f_pick(rq, model[7:0])));
        @(posedge clk);
        model = f_next(model, fw, fi, me, ms, mv, re, rw);
        @(negedge clk);
        chk({tag, " word"}, 32'(status_word), 32'(model));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", 32'(status_word), 32'h0);
        for (int s = 0; s < 4; s++) begin
            cond_sel = 2'(s);
            #1;
            chk("R1 taken after reset", 32'(taken), 32'h0);
        end
        irq_req = 8'hFF; #1;
        chk("R1 irq after reset", 32'(irq_valid), 32'h0);

        step("R5 R6 restore reserved ones", 0, 0, 0, 0, 0, 1, 16'hFFFF, 8'h00, 2'b00);
        step("R2 flags 1010", 1, 4'b1010, 0, 0, 0, 0, 0, 8'h00, 2'b01);
        for (int s = 0; s < 4; s++)
            step("R7 selector sweep", 0, 0, 0, 0, 0, 0, 0, 8'h00, 2'(s));
        step("R4 disable mask", 0, 0, 1, 0, 8'b1010_0100, 0, 0, 8'hFF, 2'b10);
        step("R8 lowest wins", 0, 0, 0, 0, 0, 0, 0, 8'b1010_0100, 2'b00);
        step("R8 masked off", 0, 0, 0, 0, 0, 0, 0, 8'b0101_1011, 2'b00);
        step("R3 enable mask", 0, 0, 1, 1, 8'b0000_0001, 0, 0, 8'h81, 2'b11);
        step("R9 flag plus mask", 1, 4'b0101, 1, 0, 8'h80, 0, 0, 8'h80, 2'b11);
        step("R5 restore beats others", 1, 4'b1111, 1, 1, 8'hFF, 1, 16'h3A5C, 8'h04, 2'b00);
        step("R10 hold", 0, 4'b1111, 0, 1, 8'hFF, 0, 16'hFFFF, 8'h00, 2'b01);

        for (int k = 0; k < 400; k++) begin
            logic [31:0] r = $urandom;
            step("R2 R3 R4 R5 R9 random",
                 r[0], 4'($urandom), r[1], r[2], 8'($urandom), (r[7:3] == 5'd0),
                 16'($urandom), 8'($urandom), r[9:8]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule